// File: doc/BRIEF.md
# Motor Drive PWM Command Generator

This block turns a speed and direction request into the two command lines of an H-bridge motor driver. A free-running period counter and a duty compare make one pulse-width waveform. A mode select then picks how that waveform reaches the two lines. In direct mode the lines carry static direction levels. In sign/magnitude mode one line is held high and the other carries the pulse train. In anti-phase mode one line carries the pulse train and the other carries its complement, so a single duty value sets both direction and strength.

In sign/magnitude mode the bridge drives the motor while the switched line is low. A larger duty therefore gives a slower motor, and full duty puts both lines high, which brakes the motor. In anti-phase mode a duty of half the period gives zero average drive. A brake request overrides every mode and forces both lines to the same level. Duty, period, direction and mode are applied only at a period boundary, so a setting change never produces a shortened or stretched pulse.

Top module: `motor_pwm_cmd`

## Requirements
- R1: While reset is asserted (rstN low), both command lines are low.
- R2: Mode code 0 (and the unused code 3) is direct mode. The lines are static: dirCw=1 gives cmdA=1, cmdB=0, and dirCw=0 gives cmdA=0, cmdB=1.
- R3: The period counter runs from 0 to period-1 and the pulse is high while the count is below the duty. Over any run of whole periods, the pulse is high for min(duty, period) cycles out of every period cycles. A period of 0 behaves like a period of 1.
- R4: A duty of 0 gives a pulse that stays low. A duty equal to or above the period gives a pulse that stays high. Neither case produces a single-cycle pulse.
- R5: Mode code 1 is sign/magnitude mode. With dirCw=1, cmdA stays high and cmdB carries the pulse.
- R6: In sign/magnitude mode with dirCw=0, cmdA carries the pulse and cmdB stays high.
- R7: Mode code 2 is anti-phase mode. cmdA carries the pulse and cmdB is its exact complement in every cycle.
- R8: A new duty, period, direction or mode takes effect only at the end of the current period. Every complete pulse has the length of either the old duty or the new duty.
- R9: With brakeReq high, one clock later both lines equal brakeHigh in every mode, and they stay there while the request is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | 0/3 direct, 1 sign/magnitude, 2 anti-phase |
| dirCw | input | 1 | 1 requests clockwise rotation, 0 counterclockwise |
| brakeReq | input | 1 | Brake override request |
| brakeHigh | input | 1 | Brake level: 1 gives both lines high, 0 gives both low |
| duty | input | CNT_W | Compare value in clock cycles |
| period | input | CNT_W | PWM period in clock cycles |
| cmdA | output | 1 | First bridge command line |
| cmdB | output | 1 | Second bridge command line |

## Verification
Both command lines are registered. A brake request or brake level seen at one rising edge appears on the lines after that edge. A new setting first waits for the end of the period that is running, and then needs one more clock to reach the lines. After every setting change, the bench therefore waits for the old period plus three clocks before it counts anything. The high-cycle counts are taken over windows of exactly four new periods, so the result does not depend on where in the period the window starts. The brake check samples one cycle after the request. The boundary check measures the length of every complete pulse around a mid-period duty change.

// File: rtl/motor_pwm_pkg.sv
package motor_pwm_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT    = 2'd0,
    MODE_SIGNMAG   = 2'd1,
    MODE_ANTIPHASE = 2'd2
  } drive_mode_e;

  // Strobes handed from the period control to the output datapath
  typedef struct packed {
    logic        pwmOn;
    drive_mode_e mode;
    logic        dirCw;
  } ctrl_strobe_t;

  function automatic drive_mode_e decodeMode(input logic [1:0] sel);
    case (sel)
      2'b01:   return MODE_SIGNMAG;
      2'b10:   return MODE_ANTIPHASE;
      default: return MODE_DIRECT;
    endcase
  endfunction

endpackage

// File: rtl/motor_pwm_ctrl.sv
module motor_pwm_ctrl
  import motor_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeReq,
  input  logic             dirReq,
  input  logic [CNT_W-1:0] dutyReq,
  input  logic [CNT_W-1:0] periodReq,
  output ctrl_strobe_t     strobe
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] actDuty;
  logic [CNT_W-1:0] actPeriod;
  drive_mode_e      actMode;
  logic             actDir;
  logic             wrap;

  // End of period: last count reached, or a zero period (acts as period 1)
  assign wrap = (actPeriod == '0) || (cnt >= (actPeriod - ONE));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      actDuty   <= '0;
      actPeriod <= '0;
      actMode   <= MODE_DIRECT;
      actDir    <= 1'b0;
    end else if (wrap) begin
      cnt       <= '0;
      actDuty   <= dutyReq;
      actPeriod <= periodReq;
      actMode   <= decodeMode(modeReq);
      actDir    <= dirReq;
    end else begin
      cnt <= cnt + ONE;
    end
  end

  always_comb begin
    strobe.pwmOn = (cnt < actDuty);
    strobe.mode  = actMode;
    strobe.dirCw = actDir;
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (actPeriod != '0) |-> (cnt < actPeriod));

  // R8
  settings_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(wrap)) |->
      ($stable(actDuty) && $stable(actPeriod) && $stable(actMode) && $stable(actDir)));

  // R3
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wrap)) |-> (cnt == '0));

endmodule

// File: rtl/motor_pwm_dp.sv
module motor_pwm_dp
  import motor_pwm_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_strobe_t strobe,
  input  logic         brakeReq,
  input  logic         brakeHigh,
  output logic         cmdA,
  output logic         cmdB
);

  logic nextA;
  logic nextB;

  always_comb begin
    nextA = 1'b0;
    nextB = 1'b0;
    if (brakeReq) begin
      nextA = brakeHigh;
      nextB = brakeHigh;
    end else begin
      case (strobe.mode)
        MODE_SIGNMAG: begin
          if (strobe.dirCw) begin
            nextA = 1'b1;
            nextB = strobe.pwmOn;
          end else begin
            nextA = strobe.pwmOn;
            nextB = 1'b1;
          end
        end
        MODE_ANTIPHASE: begin
          nextA = strobe.pwmOn;
          nextB = !strobe.pwmOn;
        end
        default: begin
          nextA = strobe.dirCw;
          nextB = !strobe.dirCw;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdA <= 1'b0;
      cmdB <= 1'b0;
    end else begin
      cmdA <= nextA;
      cmdB <= nextB;
    end
  end

  // R9
  brake_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(brakeReq)) |->
      (cmdA == $past(brakeHigh) && cmdB == $past(brakeHigh)));

  // R7
  antiphase_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(!brakeReq && strobe.mode == MODE_ANTIPHASE)) |->
      (cmdB == !cmdA));

  // R5
  signmag_cw_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(!brakeReq && strobe.mode == MODE_SIGNMAG && strobe.dirCw)) |->
      cmdA);

  // R6
  signmag_ccw_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(!brakeReq && strobe.mode == MODE_SIGNMAG && !strobe.dirCw)) |->
      cmdB);

endmodule

// File: rtl/motor_pwm_cmd.sv
module motor_pwm_cmd
  import motor_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic             dirCw,
  input  logic             brakeReq,
  input  logic             brakeHigh,
  input  logic [CNT_W-1:0] duty,
  input  logic [CNT_W-1:0] period,
  output logic             cmdA,
  output logic             cmdB
);

  ctrl_strobe_t strobe;

  motor_pwm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .modeReq   (modeSel),
    .dirReq    (dirCw),
    .dutyReq   (duty),
    .periodReq (period),
    .strobe    (strobe)
  );

  motor_pwm_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .brakeReq  (brakeReq),
    .brakeHigh (brakeHigh),
    .cmdA      (cmdA),
    .cmdB      (cmdB)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk)
    $past(!rstN) |-> (!cmdA && !cmdB));

endmodule

// File: tb/motor_pwm_cmd_tb.sv
module motor_pwm_cmd_tb;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [1:0]       modeSel = 2'd0;
  logic             dirCw = 1'b0;
  logic             brakeReq = 1'b0;
  logic             brakeHigh = 1'b0;
  logic [CNT_W-1:0] duty = '0;
  logic [CNT_W-1:0] period = '0;
  logic             cmdA;
  logic             cmdB;

  int  nTests = 0;
  int  nFail = 0;
  bit  finished = 1'b0;
  int  lastPeriod = 0;

  typedef struct {
    int    win;
    int    expA;
    int    expB;
    bit    compl;
    string tag;
  } sb_item_t;

  sb_item_t sbq[$];

  always #5 clk = ~clk;

  motor_pwm_cmd #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .dirCw(dirCw),
    .brakeReq(brakeReq), .brakeHigh(brakeHigh), .duty(duty),
    .period(period), .cmdA(cmdA), .cmdB(cmdB)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Monitor: pops each expected item and measures the lines over its window
  initial begin
    forever begin
      sb_item_t it;
      int hiA;
      int hiB;
      int badC;
      wait (sbq.size() != 0);
      it = sbq[0];
      hiA = 0; hiB = 0; badC = 0;
      for (int i = 0; i < it.win; i++) begin
        @(negedge clk);
        hiA += int'(cmdA);
        hiB += int'(cmdB);
        if (it.compl && (cmdB == cmdA)) badC++;
      end
      check(hiA == it.expA, it.tag, "cmdA high cycles", hiA, it.expA);
      check(hiB == it.expB, it.tag, "cmdB high cycles", hiB, it.expB);
      if (it.compl) check(badC == 0, it.tag, "cycles with cmdB==cmdA", badC, 0);
      void'(sbq.pop_front());
    end
  end

  // Driver: apply a setting, let it settle, push the expected counts
  task automatic runCase(input logic [1:0] m, input bit d, input int du,
                         input int pe, input int expHiA, input int expHiB,
                         input bit compl, input string tag);
    int perEff;
    int settle;
    perEff = (pe == 0) ? 1 : pe;
    settle = ((lastPeriod == 0) ? 1 : lastPeriod) + 3;
    @(negedge clk);
    modeSel = m; dirCw = d; duty = CNT_W'(du); period = CNT_W'(pe);
    lastPeriod = pe;
    repeat (settle) @(negedge clk);
    sbq.push_back('{win: 4 * perEff, expA: expHiA, expB: expHiB,
                    compl: compl, tag: tag});
    wait (sbq.size() == 0);
  endtask

  // Watchdog
  initial begin
    #2000000;
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: run did not end, actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    // R1: reset holds both lines low
    repeat (3) @(negedge clk);
    check(cmdA == 1'b0, "R1", "cmdA in reset", int'(cmdA), 0);
    check(cmdB == 1'b0, "R1", "cmdB in reset", int'(cmdB), 0);
    rstN = 1'b1;

    // R2: direct mode, static levels (window of 4 cycles each, period 0)
    runCase(2'd0, 1'b1, 0, 0, 4, 0, 1'b1, "R2 direct cw");
    runCase(2'd0, 1'b0, 7, 0, 0, 4, 1'b1, "R2 direct ccw");
    runCase(2'd3, 1'b1, 0, 5, 20, 0, 1'b0, "R2 code3 cw");

    // R5 / R3: sign-magnitude clockwise
    runCase(2'd1, 1'b1, 3, 10, 40, 12, 1'b0, "R5 smcw duty3");
    runCase(2'd1, 1'b1, 9, 10, 40, 36, 1'b0, "R5 smcw duty9");
    // R4: full duty brakes high, zero duty stays low
    runCase(2'd1, 1'b1, 10, 10, 40, 40, 1'b0, "R4 smcw full");
    runCase(2'd1, 1'b1, 0, 10, 40, 0, 1'b0, "R4 smcw zero");

    // R6: sign-magnitude counterclockwise
    runCase(2'd1, 1'b0, 2, 8, 8, 32, 1'b0, "R6 smccw duty2");

    // R7: anti-phase
    runCase(2'd2, 1'b0, 5, 10, 20, 20, 1'b1, "R7 ap half");
    runCase(2'd2, 1'b1, 8, 10, 32, 8, 1'b1, "R7 ap cw");
    runCase(2'd2, 1'b0, 2, 10, 8, 32, 1'b1, "R7 ap ccw");
    // R4: duty above period
    runCase(2'd2, 1'b0, 20, 10, 40, 0, 1'b1, "R4 ap over");
    // R3: zero period behaves like period 1
    runCase(2'd1, 1'b0, 5, 0, 4, 4, 1'b0, "R3 zero period");
    runCase(2'd2, 1'b0, 1, 3, 4, 8, 1'b1, "R3 ap period3");

    // R9: brake overrides anti-phase PWM
    runCase(2'd2, 1'b0, 3, 10, 12, 28, 1'b1, "R9 pre-brake");
    @(negedge clk);
    brakeReq = 1'b1; brakeHigh = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check(cmdA == 1'b0 && cmdB == 1'b0, "R9", "brake low lines",
            int'({cmdA, cmdB}), 0);
    end
    brakeHigh = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check(cmdA == 1'b1 && cmdB == 1'b1, "R9", "brake high lines",
            int'({cmdA, cmdB}), 3);
    end
    brakeReq = 1'b0; brakeHigh = 1'b0;

    // R8: a mid-period duty change leaves only whole pulses
    runCase(2'd1, 1'b1, 3, 10, 40, 12, 1'b0, "R8 pre-change");
    repeat (4) @(negedge clk);
    duty = CNT_W'(7);
    begin
      int runLen;
      bit seenLow;
      bit saw7;
      runLen = 0; seenLow = 1'b0; saw7 = 1'b0;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        if (cmdB) begin
          if (seenLow) runLen++;
        end else begin
          if (runLen > 0) begin
            check(runLen == 3 || runLen == 7, "R8", "pulse length", runLen, 7);
            if (runLen == 7) saw7 = 1'b1;
          end
          runLen = 0;
          seenLow = 1'b1;
        end
      end
      check(saw7, "R8", "new duty pulse seen", int'(saw7), 1);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule